// File: doc/BRIEF.md
# Column-Masked Dual-Port RAM

This block is a synchronous memory with one write port and one read port. Both ports share one clock and can be used in the same cycle. The write enable is a mask of column strobes rather than a single bit. The data word is divided into `NCOL` equal slices. On a write, only the slices whose strobe is set take the new data, and the other slices of the addressed word keep their contents. A byte-wide strobe bus is the usual case, but any even split of the word is allowed.

The write port also returns a word for the location it addresses. By default this is the word as it stands after the write: enabled columns from the input and the remaining columns from storage. A parameter selects the previous contents instead. The read port always returns the contents from before any same-cycle write. A second parameter removes the output registers so that both ports read combinationally. In that mode the write port always shows the word held before the edge. Reset clears every location and both outputs. The data width must divide evenly by the strobe count, and both address widths must lie between 2 and 31 bits. The block refuses to elaborate otherwise.

Top module: `colwrite_dpram`

## Requirements
- R1: The word is split into `NCOL` columns of `DATA_W/NCOL` bits. Strobe bit i writes bits `[i*CW +: CW]`, where column 0 holds the least significant bits. Columns whose strobe is clear keep their contents. With a zeroed 16-bit word, 4 columns and data 980, strobes 4'b0011, 4'b0100 and 4'b0110 store 212, 768 and 976.
- R2: An all-zero strobe mask changes no location.
- R3: In the registered mode, `rd_dout` shows the word at `rd_addr` one clock edge after that address is presented.
- R4: When a read and a write hit the same address at the same edge, the read returns the contents from before the write.
- R5: In the registered mode with the new-data view, `wr_dout` shows the merged word after the write, one edge after the write is presented.
- R6: With the old-data view, `wr_dout` shows the contents of `wr_addr` from before the write, one edge later.
- R7: With an all-zero mask, `wr_dout` shows the stored word at `wr_addr` in either view.
- R8: After reset, every location reads zero and both outputs are zero. A partial-column write to a location that held data before the reset stores zero in its unselected columns.
- R9: With combinational read selected, `rd_dout` and `wr_dout` show the words stored at `rd_addr` and `wr_addr` in the same cycle, before any write at the coming edge.
- R10: A 16-bit word holding 0xFFFF, written with data 980 under mask 4'b1001, afterwards reads 4084 (0x0FF4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NCOL | Column strobe mask; bit i selects column i |
| wr_addr | input | WR_AW | Write port address |
| wr_din | input | DATA_W | Write data |
| rd_addr | input | RD_AW | Read port address |
| rd_dout | output | DATA_W | Read data |
| wr_dout | output | DATA_W | Word seen at the write address (new or old view) |

## Verification
The hardest case is a location that held data, was cleared by reset, and then receives a write that sets only some strobes. The unselected columns must come back as zero and not as the data stored before the reset. The stimulus reaches this case by running a random phase that fills most locations. It then pulses reset and issues single-column writes to those locations, reading each one back. Same-address read and write collisions are also forced. A quarter of the random cycles reuse the write address for the read, and three instances with the registered new view, the registered old view and combinational read see identical inputs.

// File: rtl/colwrite_dpram_pkg.sv
package colwrite_dpram_pkg;

  typedef enum logic {
    VIEW_OLD = 1'b0,
    VIEW_NEW = 1'b1
  } wr_view_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dpram_col_merge.sv
module dpram_col_merge #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NCOL   = 4
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  input  logic [NCOL-1:0]   col_sel,
  output logic [DATA_W-1:0] merged
);

  localparam int unsigned CW = DATA_W / NCOL;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign merged[c*CW +: CW] = col_sel[c] ? new_word[c*CW +: CW] : old_word[c*CW +: CW];
  end

endmodule

// File: rtl/dpram_col_store.sv
module dpram_col_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NCOL   = 4,
  parameter int unsigned AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCOL-1:0]   col_we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] wword
);

  localparam int unsigned CW    = DATA_W / NCOL;
  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live;
  logic              any_we;

  assign any_we = |col_we;

  // A location whose live flag is clear is rewritten in full: selected
  // columns take the input, the rest take zero, so stale data never returns.
  always_ff @(posedge clk) begin
    if (!rst && any_we) begin
      for (int c = 0; c < NCOL; c++) begin
        if (col_we[c] || !live[waddr]) begin
          mem[waddr][c*CW +: CW] <= col_we[c] ? wdata[c*CW +: CW] : '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else if (any_we) begin
      live[waddr] <= 1'b1;
    end
  end

  assign rword = live[raddr] ? mem[raddr] : '0;
  assign wword = live[waddr] ? mem[waddr] : '0;

endmodule

// File: rtl/colwrite_dpram.sv
module colwrite_dpram #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NCOL       = 4,
  parameter int unsigned WR_AW      = 4,
  parameter int unsigned RD_AW      = 4,
  parameter bit          ASYNC_READ = 1'b0,
  parameter colwrite_dpram_pkg::wr_view_e WR_VIEW = colwrite_dpram_pkg::VIEW_NEW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCOL-1:0]   wr_en,
  input  logic [WR_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_din,
  input  logic [RD_AW-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_dout,
  output logic [DATA_W-1:0] wr_dout
);

  localparam int unsigned AW = colwrite_dpram_pkg::max_u(WR_AW, RD_AW);

  if ((DATA_W % NCOL) != 0) begin : g_bad_split
    $error("colwrite_dpram: DATA_W must be a multiple of NCOL");
  end
  if (WR_AW < 2 || WR_AW > 31 || RD_AW < 2 || RD_AW > 31) begin : g_bad_aw
    $error("colwrite_dpram: address widths must lie in 2..31");
  end

  logic [AW-1:0]     wa_ext;
  logic [AW-1:0]     ra_ext;
  logic [DATA_W-1:0] st_rword;
  logic [DATA_W-1:0] st_wword;
  logic [DATA_W-1:0] merged;

  assign wa_ext = AW'(wr_addr);
  assign ra_ext = AW'(rd_addr);

  dpram_col_store #(
    .DATA_W(DATA_W),
    .NCOL  (NCOL),
    .AW    (AW)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .col_we(wr_en),
    .waddr (wa_ext),
    .wdata (wr_din),
    .raddr (ra_ext),
    .rword (st_rword),
    .wword (st_wword)
  );

  dpram_col_merge #(
    .DATA_W(DATA_W),
    .NCOL  (NCOL)
  ) u_merge (
    .old_word(st_wword),
    .new_word(wr_din),
    .col_sel (wr_en),
    .merged  (merged)
  );

  if (ASYNC_READ) begin : g_comb_out
    assign rd_dout = rst ? '0 : st_rword;
    assign wr_dout = rst ? '0 : st_wword;
  end else begin : g_reg_out
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_dout <= '0;
        wr_dout <= '0;
      end else begin
        rd_dout <= st_rword;
        wr_dout <= (WR_VIEW == colwrite_dpram_pkg::VIEW_NEW) ? merged : st_wword;
      end
    end
  end

endmodule

// File: rtl/colwrite_dpram_chk.sv
module colwrite_dpram_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned NCOL       = 4,
  parameter int unsigned WR_AW      = 4,
  parameter int unsigned RD_AW      = 4,
  parameter bit          ASYNC_READ = 1'b0,
  parameter colwrite_dpram_pkg::wr_view_e WR_VIEW = colwrite_dpram_pkg::VIEW_NEW
) (
  input logic              clk,
  input logic              rst,
  input logic [NCOL-1:0]   wr_en,
  input logic [WR_AW-1:0]  wr_addr,
  input logic [DATA_W-1:0] wr_din,
  input logic [RD_AW-1:0]  rd_addr,
  input logic [DATA_W-1:0] rd_dout,
  input logic [DATA_W-1:0] wr_dout
);

  localparam int unsigned CW = DATA_W / NCOL;

  logic [DATA_W-1:0] col_mask;
  logic              hit;

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      col_mask[c*CW +: CW] = {CW{wr_en[c]}};
    end
  end

  assign hit = (32'(rd_addr) == 32'(wr_addr));

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_dout == '0 && wr_dout == '0)); // R8

  if (ASYNC_READ) begin : g_async
    AST_ASYNC_HIT_SAME: assert property (@(posedge clk) disable iff (rst)
      hit |-> (rd_dout == wr_dout)); // R9
  end else begin : g_sync
    AST_RD_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(wr_en, 2) == '0 &&
       $past(rd_addr) == $past(rd_addr, 2)) |-> $stable(rd_dout)); // R2
    AST_HIT_OLD_COLS: assert property (@(posedge clk) disable iff (rst)
      hit |=> (((rd_dout ^ wr_dout) & ~$past(col_mask)) == '0)); // R4
    if (WR_VIEW == colwrite_dpram_pkg::VIEW_NEW) begin : g_new
      AST_NEW_COLS_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        (|wr_en) |=> (((wr_dout ^ $past(wr_din)) & $past(col_mask)) == '0)); // R5
    end else begin : g_old
      AST_OLD_VIEW_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |=> (rd_dout == wr_dout)); // R6
    end
  end

endmodule

bind colwrite_dpram colwrite_dpram_chk #(
  .DATA_W    (DATA_W),
  .NCOL      (NCOL),
  .WR_AW     (WR_AW),
  .RD_AW     (RD_AW),
  .ASYNC_READ(ASYNC_READ),
  .WR_VIEW   (WR_VIEW)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_din (wr_din),
  .rd_addr(rd_addr),
  .rd_dout(rd_dout),
  .wr_dout(wr_dout)
);

// File: tb/test_colwrite_dpram.sv
module test_colwrite_dpram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  wr_en = '0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_din = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_n, wr_n, rd_o, wr_o, rd_a, wr_a;

  logic [15:0] model [16];
  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  colwrite_dpram i_colwrite_dpram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_din(wr_din),
    .rd_addr(rd_addr), .rd_dout(rd_n), .wr_dout(wr_n)
  );

  colwrite_dpram #(.WR_VIEW(colwrite_dpram_pkg::VIEW_OLD)) i_colwrite_dpram_old (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_din(wr_din),
    .rd_addr(rd_addr), .rd_dout(rd_o), .wr_dout(wr_o)
  );

  colwrite_dpram #(.ASYNC_READ(1'b1)) i_colwrite_dpram_async (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_din(wr_din),
    .rd_addr(rd_addr), .rd_dout(rd_a), .wr_dout(wr_a)
  );

  function automatic logic [15:0] merge(input logic [15:0] old_w, input logic [15:0] new_w,
                                        input logic [3:0] sel);
    logic [15:0] r;
    for (int c = 0; c < 4; c++) r[c*4 +: 4] = sel[c] ? new_w[c*4 +: 4] : old_w[c*4 +: 4];
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Called just after a rising edge; leaves just after the next one.
  task automatic cycle(input logic [3:0] we, input logic [3:0] wa, input logic [15:0] wd,
                       input logic [3:0] ra, input string tag);
    logic [15:0] e_rd, e_old, e_new;
    wr_en = we; wr_addr = wa; wr_din = wd; rd_addr = ra;
    #1;
    e_rd  = model[ra];
    e_old = model[wa];
    e_new = merge(model[wa], wd, we);
    chk("R9", "async rd_dout", rd_a, e_rd);
    chk("R9", "async wr_dout", wr_a, e_old);
    @(posedge clk); #1;
    if (we != '0) model[wa] = e_new;
    chk(tag, "rd_dout", rd_n, e_rd);
    chk(tag, "old-view rd_dout", rd_o, e_rd);
    chk("R5 R7", "new-view wr_dout", wr_n, e_new);
    chk("R6", "old-view wr_dout", wr_o, e_old);
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = '0;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    #1;
    chk("R8", "rd_dout after reset", rd_n, 16'h0);
    chk("R8", "wr_dout after reset", wr_n, 16'h0);
    chk("R8", "async rd_dout after reset", rd_a, 16'h0);
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // Column split examples on zeroed locations
    cycle(4'b0011, 4'd5, 16'd980, 4'd0, "R3");
    cycle(4'b0100, 4'd6, 16'd980, 4'd5, "R1");
    chk("R1", "mask 0011 word", rd_n, 16'd212);
    cycle(4'b0110, 4'd7, 16'd980, 4'd6, "R1");
    chk("R1", "mask 0100 word", rd_n, 16'd768);
    cycle(4'b0000, 4'd0, 16'h0, 4'd7, "R1");
    chk("R1", "mask 0110 word", rd_n, 16'd976);

    // Merge into an all-ones word
    cycle(4'b1111, 4'd3, 16'hFFFF, 4'd0, "R3");
    cycle(4'b1001, 4'd3, 16'd980, 4'd3, "R4");
    chk("R4", "collision returns prior word", rd_n, 16'hFFFF);
    cycle(4'b0000, 4'd3, 16'h1234, 4'd3, "R2");
    chk("R10", "merged word", rd_n, 16'd4084);
    chk("R7", "idle write port view", wr_n, 16'd4084);
    cycle(4'b0000, 4'd9, 16'hBEEF, 4'd3, "R2");
    chk("R2", "zero mask keeps word", rd_n, 16'd4084);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      logic [3:0] we, wa, ra;
      we = ($urandom_range(0, 9) < 3) ? 4'b0000 : 4'($urandom);
      wa = 4'($urandom);
      ra = ($urandom_range(0, 3) == 0) ? wa : 4'($urandom);
      cycle(we, wa, 16'($urandom), ra, (ra == wa) ? "R4" : "R3");
    end
    for (int i = 0; i < 16; i++) cycle(4'b1111, 4'(i), 16'hA5C3 ^ 16'(i), 4'(i), "R4");

    // Reset over stale contents, then partial writes
    do_reset();
    for (int i = 0; i < 16; i++) begin
      cycle(4'b0000, 4'd0, 16'h0, 4'(i), "R8");
      if (i > 0) chk("R8", "cleared location", rd_n, 16'h0);
    end
    cycle(4'b0001, 4'd2, 16'hABCD, 4'd0, "R8");
    cycle(4'b0100, 4'd4, 16'h5678, 4'd2, "R8");
    chk("R8", "partial write after reset", rd_n, 16'h000D);
    cycle(4'b0000, 4'd0, 16'h0, 4'd4, "R8");
    chk("R8", "partial write after reset", rd_n, 16'h0600);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule